// File: doc/BRIEF.md
# Memory fault flag and interrupt controller

This block holds the fault-reporting control and status logic that sits beside an error-corrected nonvolatile memory array. An external correction checker raises one-cycle pulses that mark a single-bit fault or a double-bit fault on a read. The block turns those pulses into sticky status flags and gates them with per-flag interrupt enables. A command-complete status flag from the command sequencer is gated into a third interrupt request.

Software reaches the block through a byte-wide register port with a combinational read. There are three registers. A control register holds the command-complete interrupt enable, an ignore control for single-bit faults and two force-fault test controls. An error configuration register holds the two fault interrupt enables. A status register holds the two sticky fault flags and is cleared by writing 1.

The force controls let software make any array read raise a fault flag, so that interrupt handlers can be exercised without a real fault.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset, the registers at offsets 0x4, 0x5 and 0x6 read 0x00 and all three interrupt outputs are low.
- R2: The error configuration register is at offset 0x5. Bit 1 is the double-fault interrupt enable and bit 0 is the single-fault interrupt enable. Bits 7..2 read as zero whatever was written to them.
- R3: `cmdIrq` is high exactly when `cmdDoneIn` is high and the command-complete enable is set. That enable is bit 0 of the control register at offset 0x4.
- R4: Fault flags are set only in a cycle where `arrayRead` is high. The status register is at offset 0x6: bit 0 is the single-fault flag and bit 1 is the double-fault flag. A real single fault needs `singleFaultIn`; a real double fault needs `doubleFaultIn`. Status bits 7..2 read as zero.
- R5: While the ignore control (control bit 1) is set, a detected single-bit fault leaves the single flag clear and raises no interrupt. A forced single fault still sets the flag.
- R6: While force-double (control bit 2) is set, every array read sets the double flag. While force-single (control bit 3) is set, every array read sets the single flag.
- R7: Each fault interrupt output is its flag AND its enable. Clearing either one drops the output from the cycle after the write.
- R8: The flags are sticky. Writing 1 to a status bit clears that flag, and writing 0 to it has no effect.
- R9: The force controls stay set across array reads until software writes 0 to them. Control bits 7..4 read as zero.
- R10: A flag that is set and cleared in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| arrayRead | input | 1 | One-cycle pulse per array read |
| singleFaultIn | input | 1 | Single-bit fault detected on this read |
| doubleFaultIn | input | 1 | Double-bit fault detected on this read |
| cmdDoneIn | input | 1 | Command-complete status flag |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| cmdIrq | output | 1 | Command-complete interrupt request |
| singleIrq | output | 1 | Single-fault interrupt request |
| doubleIrq | output | 1 | Double-fault interrupt request |

## Verification
The checker watches several rules on every cycle:
- the command interrupt never rises without its status input;
- a fault flag never rises outside an array read;
- a held flag survives any cycle without a write-1 clear;
- a forced read always leaves its flag set, even against a clear;
- an ignored real single fault never sets the single flag.

Only the bench scenarios can show the rest:
- the exact register layout and the read-back of reserved bits;
- that force controls persist over several reads;
- that interrupts drop after an enable is cleared;
- how the ignore and force controls interact.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CTL    = 2'd1,
    SEL_ERRCFG = 2'd2,
    SEL_STAT   = 2'd3
  } rd_sel_t;

  typedef struct packed {
    logic    wrCtl;
    logic    wrErrCfg;
    logic    wrStat;
    rd_sel_t rdSel;
  } reg_strobe_t;
endpackage

// File: rtl/fault_irq_decode.sv
module fault_irq_decode
  import fault_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CTL_OFS    = 4,
  parameter int ERRCFG_OFS = 5,
  parameter int STAT_OFS   = 6
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output reg_strobe_t       strobes
);
  localparam logic [ADDR_W-1:0] CtlA    = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] ErrCfgA = ADDR_W'(ERRCFG_OFS);
  localparam logic [ADDR_W-1:0] StatA   = ADDR_W'(STAT_OFS);

  always_comb begin
    strobes = '0;
    strobes.rdSel = SEL_NONE;
    if (regAddr == CtlA) begin
      strobes.rdSel = SEL_CTL;
      strobes.wrCtl = regWr;
    end else if (regAddr == ErrCfgA) begin
      strobes.rdSel = SEL_ERRCFG;
      strobes.wrErrCfg = regWr;
    end else if (regAddr == StatA) begin
      strobes.rdSel = SEL_STAT;
      strobes.wrStat = regWr;
    end
  end
endmodule

// File: rtl/fault_irq_datapath.sv
module fault_irq_datapath
  import fault_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  reg_strobe_t       strobes,
  input  logic [DATA_W-1:0] wdata,
  input  logic              arrayRead,
  input  logic              singleFaultIn,
  input  logic              doubleFaultIn,
  input  logic              cmdDoneIn,
  output logic [DATA_W-1:0] rdata,
  output logic              cmdIrq,
  output logic              singleIrq,
  output logic              doubleIrq,
  output logic              singleFlag,
  output logic              doubleFlag,
  output logic              ignoreSingle,
  output logic              forceSingle,
  output logic              forceDouble
);
  logic cmdIe, singleIe, doubleIe;
  logic singleSet, doubleSet, singleClr, doubleClr;
  logic [DATA_W-1:0] unusedWdata;

  assign unusedWdata = wdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdIe        <= 1'b0;
      ignoreSingle <= 1'b0;
      forceDouble  <= 1'b0;
      forceSingle  <= 1'b0;
    end else if (strobes.wrCtl) begin
      cmdIe        <= wdata[0];
      ignoreSingle <= wdata[1];
      forceDouble  <= wdata[2];
      forceSingle  <= wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleIe <= 1'b0;
      doubleIe <= 1'b0;
    end else if (strobes.wrErrCfg) begin
      singleIe <= wdata[0];
      doubleIe <= wdata[1];
    end
  end

  always_comb begin
    singleSet = arrayRead && (forceSingle || (singleFaultIn && !ignoreSingle));
    doubleSet = arrayRead && (forceDouble || doubleFaultIn);
    singleClr = strobes.wrStat && wdata[0];
    doubleClr = strobes.wrStat && wdata[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleFlag <= 1'b0;
      doubleFlag <= 1'b0;
    end else begin
      if (singleSet)      singleFlag <= 1'b1;
      else if (singleClr) singleFlag <= 1'b0;
      if (doubleSet)      doubleFlag <= 1'b1;
      else if (doubleClr) doubleFlag <= 1'b0;
    end
  end

  assign cmdIrq    = cmdDoneIn && cmdIe;
  assign singleIrq = singleFlag && singleIe;
  assign doubleIrq = doubleFlag && doubleIe;

  always_comb begin
    rdata = '0;
    unique case (strobes.rdSel)
      SEL_CTL:    rdata[3:0] = {forceSingle, forceDouble, ignoreSingle, cmdIe};
      SEL_ERRCFG: rdata[1:0] = {doubleIe, singleIe};
      SEL_STAT:   rdata[1:0] = {doubleFlag, singleFlag};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CTL_OFS    = 4,
  parameter int ERRCFG_OFS = 5,
  parameter int STAT_OFS   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arrayRead,
  input  logic              singleFaultIn,
  input  logic              doubleFaultIn,
  input  logic              cmdDoneIn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              cmdIrq,
  output logic              singleIrq,
  output logic              doubleIrq
);
  reg_strobe_t strobes;
  logic singleFlag, doubleFlag, ignoreSingle, forceSingle, forceDouble;

  fault_irq_decode #(
    .ADDR_W(ADDR_W), .CTL_OFS(CTL_OFS),
    .ERRCFG_OFS(ERRCFG_OFS), .STAT_OFS(STAT_OFS)
  ) u_decode (
    .regWr(regWr), .regAddr(regAddr), .strobes(strobes)
  );

  fault_irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(regWdata),
    .arrayRead(arrayRead), .singleFaultIn(singleFaultIn),
    .doubleFaultIn(doubleFaultIn), .cmdDoneIn(cmdDoneIn),
    .rdata(regRdata), .cmdIrq(cmdIrq), .singleIrq(singleIrq),
    .doubleIrq(doubleIrq), .singleFlag(singleFlag), .doubleFlag(doubleFlag),
    .ignoreSingle(ignoreSingle), .forceSingle(forceSingle),
    .forceDouble(forceDouble)
  );
endmodule

// File: rtl/fault_irq_ctrl_checker.sv
module fault_irq_ctrl_checker #(
  parameter int ADDR_W     = 4,
  parameter int ERRCFG_OFS = 5,
  parameter int STAT_OFS   = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              arrayRead,
  input logic              singleFaultIn,
  input logic              cmdDoneIn,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWdata,
  input logic [7:0]        regRdata,
  input logic              cmdIrq,
  input logic              singleIrq,
  input logic              singleFlag,
  input logic              doubleFlag,
  input logic              ignoreSingle,
  input logic              forceSingle,
  input logic              forceDouble
);
  logic statClrSingle, statClrDouble;
  assign statClrSingle = regWr && (regAddr == ADDR_W'(STAT_OFS)) && regWdata[0];
  assign statClrDouble = regWr && (regAddr == ADDR_W'(STAT_OFS)) && regWdata[1];

  p_errcfg_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ERRCFG_OFS)) |-> (regRdata[7:2] == 6'd0));

  p_cmd_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdIrq |-> cmdDoneIn);

  p_flag_origin_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(singleFlag) || $rose(doubleFlag)) |-> $past(arrayRead));

  p_ignore_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (arrayRead && singleFaultIn && ignoreSingle && !forceSingle && !singleFlag)
      |=> !singleFlag);

  p_force_double_r6: assert property (@(posedge clk) disable iff (!rstN)
    (arrayRead && forceDouble) |=> doubleFlag);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    singleIrq |-> singleFlag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (singleFlag && !statClrSingle) |=> singleFlag);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (arrayRead && forceDouble && statClrDouble) |=> doubleFlag);
endmodule

bind fault_irq_ctrl fault_irq_ctrl_checker #(
  .ADDR_W(ADDR_W), .ERRCFG_OFS(ERRCFG_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .arrayRead(arrayRead), .singleFaultIn(singleFaultIn),
  .cmdDoneIn(cmdDoneIn), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .cmdIrq(cmdIrq),
  .singleIrq(singleIrq), .singleFlag(singleFlag), .doubleFlag(doubleFlag),
  .ignoreSingle(ignoreSingle), .forceSingle(forceSingle),
  .forceDouble(forceDouble)
);

// File: tb/sim_fault_irq_ctrl.sv
`timescale 1ns/1ps
module sim_fault_irq_ctrl;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arrayRead = 1'b0, singleFaultIn = 1'b0, doubleFaultIn = 1'b0;
  logic cmdDoneIn = 1'b0, regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic cmdIrq, singleIrq, doubleIrq;

  int checks = 0;
  int errors = 0;
  logic rdReq = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  fault_irq_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .arrayRead(arrayRead),
    .singleFaultIn(singleFaultIn), .doubleFaultIn(doubleFaultIn),
    .cmdDoneIn(cmdDoneIn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cmdIrq(cmdIrq),
    .singleIrq(singleIrq), .doubleIrq(doubleIrq)
  );

  // Monitor: pops one expected read value per requested read
  always @(posedge clk) begin
    if (rdReq) begin
      #1;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard underflow act=%02h exp=none", regRdata);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdata !== e) begin
          errors++;
          $display("FAIL %s read act=%02h exp=%02h", t, regRdata, e);
        end
      end
    end
  end

  task automatic regRead(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    regAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic readPulse(input logic rd, input logic sf, input logic df);
    @(negedge clk);
    arrayRead = rd; singleFaultIn = sf; doubleFaultIn = df;
    @(negedge clk);
    arrayRead = 1'b0; singleFaultIn = 1'b0; doubleFaultIn = 1'b0;
  endtask

  task automatic checkIrq(input logic c, input logic s, input logic d, input string t);
    @(negedge clk);
    checks++;
    if ({cmdIrq, singleIrq, doubleIrq} !== {c, s, d}) begin
      errors++;
      $display("FAIL %s irq act=%b%b%b exp=%b%b%b", t, cmdIrq, singleIrq, doubleIrq, c, s, d);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkIrq(0, 0, 0, "R1");
    regRead(4'h4, 8'h00, "R1 ctl");
    regRead(4'h5, 8'h00, "R1 errcfg");
    regRead(4'h6, 8'h00, "R1 stat");
    // R2 error config layout
    regWrite(4'h5, 8'hFF);
    regRead(4'h5, 8'h03, "R2");
    // R3 command interrupt
    cmdDoneIn = 1'b1;
    checkIrq(0, 0, 0, "R3 enable off");
    regWrite(4'h4, 8'h01);
    checkIrq(1, 0, 0, "R3 enable on");
    cmdDoneIn = 1'b0;
    checkIrq(0, 0, 0, "R3 flag low");
    // R4 real single fault
    readPulse(1, 1, 0);
    regRead(4'h6, 8'h01, "R4 single");
    checkIrq(0, 1, 0, "R4 single irq");
    // R7 enable cleared drops irq, flag stays
    regWrite(4'h5, 8'h02);
    checkIrq(0, 0, 0, "R7 enable off");
    regRead(4'h6, 8'h01, "R7 flag held");
    // R8 write 0 no effect, write 1 clears
    regWrite(4'h6, 8'h00);
    regRead(4'h6, 8'h01, "R8 write0");
    regWrite(4'h6, 8'h01);
    regRead(4'h6, 8'h00, "R8 w1c");
    // R4 fault without array read ignored
    readPulse(0, 1, 1);
    regRead(4'h6, 8'h00, "R4 no read");
    // R5 ignore single
    regWrite(4'h4, 8'h02);
    readPulse(1, 1, 0);
    regRead(4'h6, 8'h00, "R5 ignored");
    readPulse(1, 0, 1);
    regRead(4'h6, 8'h02, "R4 double");
    checkIrq(0, 0, 1, "R7 double irq");
    regWrite(4'h6, 8'h02);
    regRead(4'h6, 8'h00, "R8 clear double");
    checkIrq(0, 0, 0, "R7 flag cleared");
    // R6 / R9 force double
    regWrite(4'h4, 8'h04);
    readPulse(1, 0, 0);
    regRead(4'h6, 8'h02, "R6 forced double");
    readPulse(1, 0, 0);
    regRead(4'h4, 8'h04, "R9 force persists");
    // R10 clear and set in the same cycle
    @(negedge clk);
    regWr = 1'b1; regAddr = 4'h6; regWdata = 8'h02; arrayRead = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0; arrayRead = 1'b0;
    regRead(4'h6, 8'h02, "R10 set wins");
    regWrite(4'h4, 8'hF0);
    regRead(4'h4, 8'h00, "R9 force cleared by 0");
    regWrite(4'h6, 8'h02);
    readPulse(1, 0, 0);
    regRead(4'h6, 8'h00, "R9 no force after clear");
    // R5 / R6 forced single overrides ignore
    regWrite(4'h4, 8'h0A);
    readPulse(1, 0, 0);
    regRead(4'h6, 8'h01, "R5 forced single with ignore");
    checkIrq(0, 0, 0, "R7 single enable off");
    regWrite(4'h5, 8'h01);
    checkIrq(0, 1, 0, "R7 single enable on");
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard leftover act=%0d exp=0", expQ.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule